// File: doc/BRIEF.md
# Accumulator Datapath with Packed Command Decode

This block is the arithmetic and register core of a small accumulator machine. It holds an accumulator, a second operand register and four condition flags: carry, zero, signed overflow and equality. Each cycle in which the enable input is high, one command word is decoded. The block then updates the accumulator, the operand register and the flags together at the next clock edge.

The command word holds three fields. A group field chooses the command family. An operation field chooses the command within that family. A source field chooses where the second operand comes from: memory read data, the immediate operand, the B register or the constant one. The sequencer that surrounds the block supplies memory read data, the immediate and the current program counter. It takes the accumulator back out as store data. Program sequencing, the stack pointer and the memories are outside this block.

Top module: `accu_datapath`

## Requirements
- R1: While `rst_n` is low, the accumulator, B and all four flags read zero.
- R2: While `en` is low, no register or flag changes, whatever the command inputs are.
- R3: The command is laid out as `cmd[7:6]` group, `cmd[5:2]` operation and `cmd[1:0]` source. The group values are 00 for arithmetic/logic, 01 for shift/negate, 10 for move/clear and 11 for no operation. The source values are 00 for memory data, 01 for the immediate, 10 for B and 11 for the constant 1.
- R4: In group 00, operation 0000 sets A to A plus the operand and 0001 sets A to A minus the operand, both modulo 2^W. With source 11 these act as increment and decrement.
- R5: Add sets C to the carry-out and subtract sets C to the borrow (A below the operand, unsigned). Both set OV on two's-complement overflow.
- R6: Every command in groups 00 and 01 that writes A sets Z exactly when the new A is zero. No other command changes Z, except clear-Z.
- R7: Subtract sets EQ to (A equals the operand). All other commands leave EQ unchanged.
- R8: In group 00, 0100 is AND, 0101 is OR and 0110 is XOR of A with the operand, and 1100 is NOT A. These leave C and OV unchanged.
- R9: Group 01, operation 0000, sets A to its two's-complement negation. C and OV are unchanged.
- R10: In group 01, 0001 is an arithmetic right shift (the MSB is kept and copied down). 0010 keeps the MSB, moves bits W-3..0 up one place and puts 0 in bit 0. 0011 is a logical right shift and 0100 is a logical left shift, both filling with 0. C is unchanged.
- R11: Group 01, 0101, rotates right through carry: C goes into the MSB and the old bit 0 goes into C. Group 01, 0110, rotates left through carry: C goes into bit 0 and the old MSB goes into C.
- R12: In group 10, 0000 loads A from memory data, 0001 loads B from the selected source and 0010 loads A from `pc`. Flags are unchanged.
- R13: In group 10, 0011 clears Z, 0100 clears OV, 0101 clears C and 0110 clears A, and each touches nothing else. Group 11 and any unassigned operation code change nothing.
- R14: `st_data_o` always equals the current accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Execute the command this cycle |
| cmd | input | 8 | Command word (group, operation, source) |
| mem_rdata | input | W | Memory read data |
| imm | input | W | Immediate operand |
| pc | input | W | Current program counter value |
| acc_o | output | W | Accumulator |
| breg_o | output | W | B register |
| c_o | output | 1 | Carry / borrow flag |
| z_o | output | 1 | Zero flag |
| ov_o | output | 1 | Signed overflow flag |
| eq_o | output | 1 | Equality flag |
| st_data_o | output | W | Store data for memory |

## Verification
The bench targets several boundary cases:
- Adding across 0x7F and 0xFF exposes a carry taken from the wrong bit or an overflow rule based on unsigned values.
- Subtracting a larger operand exposes a borrow with inverted polarity.
- Equal operands on subtract expose an EQ flag that never sets, or one that a later logic command disturbs.
- Rotating with C at both 0 and 1 catches a rotate that drops the carry or fills with zero.
- The odd left arithmetic shift catches a design that keeps bit 6 or loses the MSB.
- Running commands with the enable low, and with unassigned codes, catches decode that leaks writes.

// File: rtl/accu_pkg.sv
package accu_pkg;

    localparam int unsigned CMD_W = 8;

    typedef enum logic [1:0] {
        GRP_ALU   = 2'b00,
        GRP_UNARY = 2'b01,
        GRP_MOVE  = 2'b10,
        GRP_NOP   = 2'b11
    } grp_e;

    typedef enum logic [1:0] {
        SRC_MEM = 2'b00,
        SRC_IMM = 2'b01,
        SRC_B   = 2'b10,
        SRC_ONE = 2'b11
    } src_e;

    // group 00 operation codes
    localparam logic [3:0] OP_ADD = 4'b0000;
    localparam logic [3:0] OP_SUB = 4'b0001;
    localparam logic [3:0] OP_AND = 4'b0100;
    localparam logic [3:0] OP_OR  = 4'b0101;
    localparam logic [3:0] OP_XOR = 4'b0110;
    localparam logic [3:0] OP_NOT = 4'b1100;

    // group 01 operation codes
    localparam logic [3:0] OP_NEG = 4'b0000;
    localparam logic [3:0] OP_ASR = 4'b0001;
    localparam logic [3:0] OP_ASL = 4'b0010;
    localparam logic [3:0] OP_LSR = 4'b0011;
    localparam logic [3:0] OP_LSL = 4'b0100;
    localparam logic [3:0] OP_RRC = 4'b0101;
    localparam logic [3:0] OP_RLC = 4'b0110;

    // group 10 operation codes
    localparam logic [3:0] OP_LDA_MEM = 4'b0000;
    localparam logic [3:0] OP_LDB     = 4'b0001;
    localparam logic [3:0] OP_LDA_PC  = 4'b0010;
    localparam logic [3:0] OP_CLR_Z   = 4'b0011;
    localparam logic [3:0] OP_CLR_OV  = 4'b0100;
    localparam logic [3:0] OP_CLR_C   = 4'b0101;
    localparam logic [3:0] OP_CLR_A   = 4'b0110;

endpackage

// File: rtl/accu_srcsel.sv
module accu_srcsel
    import accu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic [1:0]   src,
    input  logic [W-1:0] mem_rdata,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] breg,
    output logic [W-1:0] opnd
);
    localparam logic [W-1:0] ONE = W'(1);

    always_comb begin
        unique case (src_e'(src))
            SRC_MEM: opnd = mem_rdata;
            SRC_IMM: opnd = imm;
            SRC_B:   opnd = breg;
            default: opnd = ONE;
        endcase
    end
endmodule

// File: rtl/accu_alu.sv
module accu_alu
    import accu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         unary,
    input  logic [3:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] opnd,
    input  logic         c_in,
    output logic [W-1:0] res,
    output logic         c_out,
    output logic         ov_out,
    output logic         eq_out,
    output logic         wr_a,
    output logic         wr_c,
    output logic         wr_ov,
    output logic         wr_eq
);
    localparam int unsigned MSB = W - 1;

    logic [W:0]   sum_x;
    logic [W:0]   dif_x;

    always_comb begin
        sum_x  = {1'b0, a} + {1'b0, opnd};
        dif_x  = {1'b0, a} - {1'b0, opnd};
        res    = a;
        c_out  = c_in;
        ov_out = 1'b0;
        eq_out = 1'b0;
        wr_a   = 1'b0;
        wr_c   = 1'b0;
        wr_ov  = 1'b0;
        wr_eq  = 1'b0;
        if (!unary) begin
            unique case (op)
                OP_ADD: begin
                    res    = sum_x[W-1:0];
                    c_out  = sum_x[W];
                    ov_out = (a[MSB] == opnd[MSB]) && (res[MSB] != a[MSB]);
                    wr_a = 1'b1; wr_c = 1'b1; wr_ov = 1'b1;
                end
                OP_SUB: begin
                    res    = dif_x[W-1:0];
                    c_out  = dif_x[W];
                    ov_out = (a[MSB] != opnd[MSB]) && (res[MSB] != a[MSB]);
                    eq_out = (a == opnd);
                    wr_a = 1'b1; wr_c = 1'b1; wr_ov = 1'b1; wr_eq = 1'b1;
                end
                OP_AND: begin res = a & opnd; wr_a = 1'b1; end
                OP_OR:  begin res = a | opnd; wr_a = 1'b1; end
                OP_XOR: begin res = a ^ opnd; wr_a = 1'b1; end
                OP_NOT: begin res = ~a;       wr_a = 1'b1; end
                default: ;
            endcase
        end else begin
            unique case (op)
                OP_NEG: begin res = ~a + W'(1); wr_a = 1'b1; end
                OP_ASR: begin res = {a[MSB], a[MSB:1]}; wr_a = 1'b1; end
                OP_ASL: begin res = {a[MSB], a[W-3:0], 1'b0}; wr_a = 1'b1; end
                OP_LSR: begin res = {1'b0, a[MSB:1]}; wr_a = 1'b1; end
                OP_LSL: begin res = {a[W-2:0], 1'b0}; wr_a = 1'b1; end
                OP_RRC: begin
                    res = {c_in, a[MSB:1]}; c_out = a[0];
                    wr_a = 1'b1; wr_c = 1'b1;
                end
                OP_RLC: begin
                    res = {a[W-2:0], c_in}; c_out = a[MSB];
                    wr_a = 1'b1; wr_c = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/accu_datapath.sv
module accu_datapath
    import accu_pkg::*;
#(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic [7:0]   cmd,
    input  logic [W-1:0] mem_rdata,
    input  logic [W-1:0] imm,
    input  logic [W-1:0] pc,
    output logic [W-1:0] acc_o,
    output logic [W-1:0] breg_o,
    output logic         c_o,
    output logic         z_o,
    output logic         ov_o,
    output logic         eq_o,
    output logic [W-1:0] st_data_o
);
    typedef struct packed {
        logic [W-1:0] a;
        logic [W-1:0] b;
        logic         c;
        logic         z;
        logic         ov;
        logic         eq;
    } state_t;

    state_t st_d, st_q;

    logic [1:0]   grp;
    logic [3:0]   op;
    logic [1:0]   src;
    logic [W-1:0] opnd;
    logic [W-1:0] alu_res;
    logic         alu_c, alu_ov, alu_eq;
    logic         wr_a, wr_c, wr_ov, wr_eq;

    assign grp = cmd[7:6];
    assign op  = cmd[5:2];
    assign src = cmd[1:0];

    accu_srcsel #(.W(W)) srcsel_i (
        .src       (src),
        .mem_rdata (mem_rdata),
        .imm       (imm),
        .breg      (st_q.b),
        .opnd      (opnd)
    );

    accu_alu #(.W(W)) alu_i (
        .unary  (grp == GRP_UNARY),
        .op     (op),
        .a      (st_q.a),
        .opnd   (opnd),
        .c_in   (st_q.c),
        .res    (alu_res),
        .c_out  (alu_c),
        .ov_out (alu_ov),
        .eq_out (alu_eq),
        .wr_a   (wr_a),
        .wr_c   (wr_c),
        .wr_ov  (wr_ov),
        .wr_eq  (wr_eq)
    );

    always_comb begin
        st_d = st_q;
        if (en) begin
            unique case (grp_e'(grp))
                GRP_ALU, GRP_UNARY: begin
                    if (wr_a) begin
                        st_d.a = alu_res;
                        st_d.z = (alu_res == '0);
                    end
                    if (wr_c)  st_d.c  = alu_c;
                    if (wr_ov) st_d.ov = alu_ov;
                    if (wr_eq) st_d.eq = alu_eq;
                end
                GRP_MOVE: begin
                    unique case (op)
                        OP_LDA_MEM: st_d.a  = mem_rdata;
                        OP_LDB:     st_d.b  = opnd;
                        OP_LDA_PC:  st_d.a  = pc;
                        OP_CLR_Z:   st_d.z  = 1'b0;
                        OP_CLR_OV:  st_d.ov = 1'b0;
                        OP_CLR_C:   st_d.c  = 1'b0;
                        OP_CLR_A:   st_d.a  = '0;
                        default: ;
                    endcase
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o     = st_q.a;
    assign breg_o    = st_q.b;
    assign c_o       = st_q.c;
    assign z_o       = st_q.z;
    assign ov_o      = st_q.ov;
    assign eq_o      = st_q.eq;
    assign st_data_o = st_q.a;

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> $stable(acc_o) && $stable(breg_o) && $stable(c_o)
                && $stable(z_o) && $stable(ov_o) && $stable(eq_o)); // R2
    AST_ADD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd[7:2] == {GRP_ALU, OP_ADD} |=> z_o == (acc_o == '0)); // R6
    AST_LOGIC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd[7:6] == GRP_ALU && (cmd[5:2] == OP_AND || cmd[5:2] == OP_XOR)
        |=> $stable(c_o) && $stable(ov_o)); // R8
    AST_RRC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd[7:2] == {GRP_UNARY, OP_RRC} |=> c_o == $past(acc_o[0])); // R11
    AST_CLEAR_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd[7:2] == {GRP_MOVE, OP_CLR_A} |=> acc_o == '0 && $stable(z_o)); // R13
    AST_LOAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        en && cmd[7:2] == {GRP_MOVE, OP_LDA_PC} |=> acc_o == $past(pc) && $stable(c_o)); // R12
endmodule

// File: tb/accu_datapath_tb.sv
module accu_datapath_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [7:0] cmd = 8'h00;
    logic [7:0] mem_rdata = 8'h00;
    logic [7:0] imm = 8'h00;
    logic [7:0] pc = 8'h00;
    logic [7:0] acc_o, breg_o, st_data_o;
    logic       c_o, z_o, ov_o, eq_o;

    int checks = 0;
    int failures = 0;
    int ma = 0, mb = 0, mc = 0, mz = 0, mov = 0, meq = 0;

    always #5 clk = ~clk;

    accu_datapath #(.W(8)) dut_i (
        .clk(clk), .rst_n(rst_n), .en(en), .cmd(cmd), .mem_rdata(mem_rdata),
        .imm(imm), .pc(pc), .acc_o(acc_o), .breg_o(breg_o), .c_o(c_o),
        .z_o(z_o), .ov_o(ov_o), .eq_o(eq_o), .st_data_o(st_data_o)
    );

    function automatic logic [7:0] mk(input int g, input int o, input int s);
        return {g[1:0], o[3:0], s[1:0]};
    endfunction

    task automatic compare(input string tag);
        logic [7:0] ef;
        logic [7:0] af;
        checks++;
        ef = {2'b00, mc[0], mz[0], mov[0], meq[0], 2'b00};
        af = {2'b00, c_o, z_o, ov_o, eq_o, 2'b00};
        if (acc_o !== ma[7:0] || breg_o !== mb[7:0] || af !== ef || st_data_o !== ma[7:0]) begin
            failures++;
            $display("FAIL %s: actual A=%02h B=%02h C=%0d Z=%0d OV=%0d EQ=%0d SD=%02h expected A=%02h B=%02h C=%0d Z=%0d OV=%0d EQ=%0d",
                     tag, acc_o, breg_o, c_o, z_o, ov_o, eq_o, st_data_o,
                     ma[7:0], mb[7:0], mc, mz, mov, meq);
        end
    endtask

    task automatic model(input int e, input int c, input int m, input int i, input int p);
        int g, o, s, x, r;
        if (e == 0) return;
        g = (c >> 6) & 3; o = (c >> 2) & 15; s = c & 3;
        x = (s == 0) ? m : (s == 1) ? i : (s == 2) ? mb : 1;
        r = -1;
        if (g == 0) begin
            case (o)
                0: begin r = (ma + x) & 255; mc = (ma + x) > 255 ? 1 : 0;
                         mov = (((ma ^ r) & (x ^ r) & 128) != 0) ? 1 : 0; end
                1: begin r = (ma - x) & 255; mc = (ma < x) ? 1 : 0;
                         mov = (((ma ^ x) & (ma ^ r) & 128) != 0) ? 1 : 0;
                         meq = (ma == x) ? 1 : 0; end
                4: r = ma & x;
                5: r = ma | x;
                6: r = ma ^ x;
                12: r = 255 - ma;
                default: r = -1;
            endcase
        end else if (g == 1) begin
            case (o)
                0: r = (256 - ma) & 255;
                1: r = (ma >> 1) | (ma & 128);
                2: r = (ma & 128) | ((ma << 1) & 126);
                3: r = ma >> 1;
                4: r = (ma << 1) & 255;
                5: begin r = (mc << 7) | (ma >> 1); mc = ma & 1; end
                6: begin r = ((ma << 1) & 255) | mc; mc = ma >> 7; end
                default: r = -1;
            endcase
        end else if (g == 2) begin
            case (o)
                0: ma = m;
                1: mb = x;
                2: ma = p;
                3: mz = 0;
                4: mov = 0;
                5: mc = 0;
                6: ma = 0;
                default: ;
            endcase
        end
        if (r >= 0) begin ma = r; mz = (r == 0) ? 1 : 0; end
    endtask

    task automatic step(input int e, input int c, input int m, input int i, input int p,
                        input string tag);
        @(negedge clk);
        en = e[0]; cmd = c[7:0]; mem_rdata = m[7:0]; imm = i[7:0]; pc = p[7:0];
        model(e, c, m, i, p);
        @(posedge clk);
        #1;
        compare(tag);
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        checks++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        en = 1'b1; cmd = mk(2, 2, 0); pc = 8'hA5;
        repeat (3) @(posedge clk);
        #1 compare("R1 reset state");
        @(negedge clk); rst_n = 1'b1; en = 1'b0;

        step(1, mk(2, 0, 0), 8'h7F, 0, 0, "R12 load A from memory");
        step(1, mk(0, 0, 1), 0, 8'h01, 0, "R5 add 7F+1 signed overflow");
        step(1, mk(0, 0, 1), 0, 8'h80, 0, "R5 R6 add 80+80 carry zero");
        step(1, mk(0, 0, 3), 0, 0, 0, "R4 increment");
        step(1, mk(0, 1, 3), 0, 0, 0, "R4 decrement to zero");
        step(1, mk(2, 1, 1), 0, 8'h05, 0, "R12 load B immediate");
        step(1, mk(0, 1, 2), 0, 0, 0, "R5 subtract borrow");
        step(1, mk(2, 0, 0), 8'h05, 0, 0, "R12 load A 05");
        step(1, mk(0, 1, 2), 0, 0, 0, "R7 subtract equal sets EQ");
        step(1, mk(0, 4, 1), 0, 8'hF0, 0, "R7 EQ kept by logic");
        step(0, mk(0, 0, 1), 0, 8'h33, 0, "R2 enable low holds");
        step(1, mk(2, 0, 0), 8'hC3, 0, 0, "R3 source mem");
        step(1, mk(2, 1, 0), 8'h3C, 0, 0, "R3 load B from memory");
        step(1, mk(0, 4, 2), 0, 0, 0, "R8 AND");
        step(1, mk(0, 5, 2), 0, 0, 0, "R8 OR");
        step(1, mk(0, 6, 1), 0, 8'hFF, 0, "R8 XOR");
        step(1, mk(0, 12, 0), 0, 0, 0, "R8 NOT");
        step(1, mk(1, 0, 0), 0, 0, 0, "R9 negate");
        step(1, mk(2, 0, 0), 8'hC5, 0, 0, "R12 load A C5");
        step(1, mk(1, 1, 0), 0, 0, 0, "R10 arithmetic right");
        step(1, mk(1, 2, 0), 0, 0, 0, "R10 arithmetic left");
        step(1, mk(1, 3, 0), 0, 0, 0, "R10 logical right");
        step(1, mk(1, 4, 0), 0, 0, 0, "R10 logical left");
        step(1, mk(2, 5, 0), 0, 0, 0, "R13 clear C");
        step(1, mk(2, 0, 0), 8'h81, 0, 0, "R12 load A 81");
        step(1, mk(1, 5, 0), 0, 0, 0, "R11 rotate right C=0");
        step(1, mk(1, 5, 0), 0, 0, 0, "R11 rotate right C=1");
        step(1, mk(1, 6, 0), 0, 0, 0, "R11 rotate left");
        step(1, mk(1, 6, 0), 0, 0, 0, "R11 rotate left again");
        step(1, mk(2, 2, 0), 0, 0, 8'h9A, "R12 load A from PC");
        step(1, mk(2, 3, 0), 0, 0, 0, "R13 clear Z");
        step(1, mk(2, 4, 0), 0, 0, 0, "R13 clear OV");
        step(1, mk(2, 6, 0), 0, 0, 0, "R13 clear A");
        step(1, mk(3, 0, 1), 8'h11, 8'h22, 0, "R13 group 11 no effect");
        step(1, mk(0, 2, 1), 8'h11, 8'h22, 0, "R13 unassigned code no effect");
        step(1, mk(2, 0, 0), 8'h6E, 0, 0, "R14 store data follows A");
        for (int k = 0; k < 400; k++) begin
            step(($urandom % 8) != 0, $urandom % 256, $urandom % 256,
                 $urandom % 256, $urandom % 256, "R3 R4 random command");
        end
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule